// File: doc/BRIEF.md
# Half-Compare Full-Swap Atomic Memory Unit

This block sits directly in front of a small synchronous store of 128-bit words. It serves one request at a time over a valid/ready port. The request carries a byte address, an operation code, a 64-bit expected value and a 128-bit data word. Besides plain reads and writes, it executes a conditional swap. The swap reads the addressed word and compares only its low 64-bit half against the expected value. If they are equal, it writes the complete 128-bit data word in place of the old one.

The intended use is a lock-free list head. The low half holds a version tag and the high half holds a pointer. Software checks that the tag is unchanged and, in the same operation, installs a new pointer together with a new tag, without paying for a full 128-bit compare.

Every request takes the same fixed three-cycle path: fetch, judge, commit. The port refuses new requests for that whole time. No other access can therefore reach the store between the read and the conditional write of a swap. The response always returns the full previous word, a success flag and an error flag.

Top module: `half_cmp_swap_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and every word of the store reads as zero.
- R2: A swap (`req_op` = 2'b10) succeeds exactly when bits [63:0] of the stored word equal `req_expect`. Bits [127:64] of the stored word never affect the outcome.
- R3: A successful swap writes all 128 bits of `req_wdata` to the addressed word and reports `rsp_ok` = 1.
- R4: A failed swap leaves the stored word unchanged and reports `rsp_ok` = 0 with `rsp_err` = 0.
- R5: Every aligned request returns in `rsp_data` the complete 128-bit content the word held before the request, whether the swap succeeded or failed.
- R6: Call the clock edge that accepts a request (`req_valid` and `req_ready` both high) edge 0. `rsp_valid` is high only between edges 2 and 3, for exactly one cycle. `req_ready` is low from edge 0 until edge 3.
- R7: An address with bits [3:0] not all zero is misaligned. It yields `rsp_err` = 1, `rsp_ok` = 0 and `rsp_data` = 0, and the store is not written, whatever the operation.
- R8: A plain write (`req_op` = 2'b01) stores `req_wdata` unconditionally and reports `rsp_ok` = 1. A plain read (2'b00, and also 2'b11) reports `rsp_ok` = 1 and never writes.
- R9: A request held valid while a swap is in progress is not accepted until the swap has retired. A write to the same word that was waiting therefore lands after the swap's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_op | input | 2 | 00 read, 01 write, 10 half-compare swap, 11 read |
| req_addr | input | ADDR_W (8) | Byte address; bits [3:0] must be zero |
| req_expect | input | 64 | Expected low-half value for a swap |
| req_wdata | input | 128 | Data for a write, or replacement word for a swap |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_data | output | 128 | Previous word content (zero on error) |
| rsp_ok | output | 1 | Operation took effect as requested |
| rsp_err | output | 1 | Misaligned address, nothing done |

## Verification
Swaps are tried against stored words whose low half matches exactly, and against words that differ only in bit 0 or only in bit 63 of the low half. This separates a true 64-bit compare from a truncated one. Other swaps use a matching low half with an upper half that differs from every other field in the request. That shows the upper half is neither compared nor left behind on success. Misaligned swaps and writes that would otherwise succeed confirm that the error path suppresses the write. A write held valid through a swap to the same word shows that it waits and then overwrites the swap's result.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

    localparam int unsigned WORD_W = 128;
    localparam int unsigned HALF_W = 64;
    localparam int unsigned OFS_W  = 4;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SWAP  = 2'b10,
        OP_SPARE = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FETCH,
        PH_JUDGE,
        PH_COMMIT
    } phase_e;

    typedef struct packed {
        op_e               op;
        logic              misalign;
        logic [HALF_W-1:0] expect_lo;
        logic [WORD_W-1:0] wdata;
    } job_t;

    typedef struct packed {
        logic ok;
        logic err;
        logic store;
    } verdict_t;

    function automatic logic low_half_equal(input logic [WORD_W-1:0] word,
                                            input logic [HALF_W-1:0] tag);
        return word[HALF_W-1:0] == tag;
    endfunction

    function automatic logic off_grid(input logic [OFS_W-1:0] low_bits);
        return |low_bits;
    endfunction

endpackage

// File: rtl/hcs_sequencer.sv
module hcs_sequencer
    import hcs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   accept,
    output phase_e phase
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE:   if (accept) phase <= PH_FETCH;
                PH_FETCH:  phase <= PH_JUDGE;
                PH_JUDGE:  phase <= PH_COMMIT;
                default:   phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hcs_store.sv
module hcs_store
    import hcs_pkg::*;
#(
    parameter int unsigned WORDS = 16,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word
);
    logic [WORD_W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) cells[i] <= '0;
        end else if (wr_en) begin
            cells[wr_idx] <= wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_word <= '0;
        else if (rd_en) rd_word <= cells[rd_idx];
    end
endmodule

// File: rtl/hcs_judge.sv
module hcs_judge
    import hcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              judge_en,
    input  job_t              job,
    input  logic [WORD_W-1:0] fetched,
    output verdict_t          verdict
);
    verdict_t next_v;

    always_comb begin
        next_v = '0;
        if (job.misalign) begin
            next_v.err = 1'b1;
        end else begin
            case (job.op)
                OP_WRITE: begin
                    next_v.ok    = 1'b1;
                    next_v.store = 1'b1;
                end
                OP_SWAP: begin
                    next_v.ok    = low_half_equal(fetched, job.expect_lo);
                    next_v.store = next_v.ok;
                end
                default: next_v.ok = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) verdict <= '0;
        else if (judge_en) verdict <= next_v;
    end
endmodule

// File: rtl/half_cmp_swap_unit.sv
module half_cmp_swap_unit
    import hcs_pkg::*;
#(
    parameter int unsigned WORDS  = 16,
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [HALF_W-1:0]   req_expect,
    input  logic [WORD_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [WORD_W-1:0]   rsp_data,
    output logic                rsp_ok,
    output logic                rsp_err
);
    phase_e            phase;
    job_t              job;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] fetched;
    verdict_t          verdict;
    logic              accept;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            job <= '0;
            idx <= '0;
        end else if (accept) begin
            job.op        <= op_e'(req_op);
            job.misalign  <= off_grid(req_addr[OFS_W-1:0]);
            job.expect_lo <= req_expect;
            job.wdata     <= req_wdata;
            idx           <= req_addr[OFS_W +: IDX_W];
        end
    end

    hcs_sequencer i_seq (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .phase  (phase)
    );

    hcs_store #(.WORDS(WORDS)) i_store (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (phase == PH_FETCH),
        .rd_idx  (idx),
        .rd_word (fetched),
        .wr_en   ((phase == PH_COMMIT) && verdict.store),
        .wr_idx  (idx),
        .wr_word (job.wdata)
    );

    hcs_judge i_judge (
        .clk      (clk),
        .rst      (rst),
        .judge_en (phase == PH_JUDGE),
        .job      (job),
        .fetched  (fetched),
        .verdict  (verdict)
    );

    assign rsp_valid = (phase == PH_COMMIT);
    assign rsp_ok    = verdict.ok;
    assign rsp_err   = verdict.err;
    assign rsp_data  = verdict.err ? '0 : fetched;
endmodule

// File: rtl/hcs_checker.sv
module hcs_checker (
    input logic         clk,
    input logic         rst,
    input logic         req_valid,
    input logic         req_ready,
    input logic         rsp_valid,
    input logic         rsp_ok,
    input logic         rsp_err,
    input logic [127:0] rsp_data
);
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !rsp_valid));

    p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_fixed_latency_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> ##3 rsp_valid);

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    p_no_accept_during_resp_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    p_error_clean_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (!rsp_ok && rsp_data == '0));
endmodule

bind half_cmp_swap_unit hcs_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .rsp_err   (rsp_err),
    .rsp_data  (rsp_data)
);

// File: tb/test_half_cmp_swap_unit.sv
`timescale 1ns/1ps
module test_half_cmp_swap_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   req_op = 2'b00;
    logic [7:0]   req_addr = '0;
    logic [63:0]  req_expect = '0;
    logic [127:0] req_wdata = '0;
    logic         rsp_valid;
    logic [127:0] rsp_data;
    logic         rsp_ok;
    logic         rsp_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [127:0] model [16];

    always #2.5 clk = ~clk;

    half_cmp_swap_unit i_half_cmp_swap_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_expect(req_expect),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_ok(rsp_ok), .rsp_err(rsp_err)
    );

    task automatic chk(input bit good, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Issue one request, check timing (R6), capture the response.
    task automatic issue(input logic [1:0] op, input logic [7:0] addr,
                         input logic [63:0] ex, input logic [127:0] wd,
                         output logic [127:0] d, output logic ok, output logic err);
        @(negedge clk);
        req_op = op; req_addr = addr; req_expect = ex; req_wdata = wd;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!rsp_valid && !req_ready, "R6", "cycle 1 quiet/busy", {126'd0, rsp_valid, req_ready}, 128'd0);
        @(negedge clk);
        chk(!rsp_valid && !req_ready, "R6", "cycle 2 quiet/busy", {126'd0, rsp_valid, req_ready}, 128'd0);
        @(negedge clk);
        chk(rsp_valid && !req_ready, "R6", "cycle 3 response", {126'd0, rsp_valid, req_ready}, 128'd2);
        d = rsp_data; ok = rsp_ok; err = rsp_err;
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R6", "back to idle", {126'd0, rsp_valid, req_ready}, 128'd1);
    endtask

    // Run a request and compare against the bench's own model.
    task automatic run(input logic [1:0] op, input logic [7:0] addr,
                       input logic [63:0] ex, input logic [127:0] wd, input string req);
        logic [127:0] d, e_d;
        logic ok, err, e_ok, e_err, e_wr;
        int i;
        i = addr[7:4];
        e_err = (addr[3:0] != 4'd0);
        e_d   = e_err ? 128'd0 : model[i];
        if (e_err) begin
            e_ok = 1'b0; e_wr = 1'b0;
        end else if (op == 2'b01) begin
            e_ok = 1'b1; e_wr = 1'b1;
        end else if (op == 2'b10) begin
            e_ok = (model[i][63:0] == ex); e_wr = e_ok;
        end else begin
            e_ok = 1'b1; e_wr = 1'b0;
        end
        issue(op, addr, ex, wd, d, ok, err);
        chk(d == e_d, req, "rsp_data", d, e_d);
        chk(ok == e_ok, req, "rsp_ok", {127'd0, ok}, {127'd0, e_ok});
        chk(err == e_err, req, "rsp_err", {127'd0, err}, {127'd0, e_err});
        if (e_wr) model[i] = wd;
    endtask

    task automatic t_reset_r1();
        chk(req_ready && !rsp_valid, "R1", "idle after reset", {126'd0, req_ready, rsp_valid}, 128'd2);
        run(2'b00, 8'h00, '0, '0, "R1");
        run(2'b00, 8'hF0, '0, '0, "R1");
    endtask

    task automatic t_plain_r8();
        run(2'b01, 8'h10, '0, 128'h1111_2222_3333_4444_5555_6666_7777_8888, "R8");
        run(2'b01, 8'h20, '0, 128'hDEAD_BEEF_0000_0001_CAFE_F00D_0000_0002, "R8");
        run(2'b00, 8'h10, '0, 128'hFFFF, "R8");
        run(2'b11, 8'h20, '0, 128'hFFFF, "R8");
        run(2'b00, 8'h20, '0, '0, "R8");
    endtask

    task automatic t_swap_hit_r3();
        run(2'b01, 8'h30, '0, {64'hAAAA_0000_AAAA_0000, 64'h0000_0000_0000_0007}, "R3");
        run(2'b10, 8'h30, 64'h7, {64'h5555_1234_5555_1234, 64'h0000_0000_0000_0008}, "R3");
        run(2'b00, 8'h30, '0, '0, "R3");
    endtask

    task automatic t_upper_ignored_r2();
        run(2'b01, 8'h40, '0, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF}, "R2");
        run(2'b10, 8'h40, 64'h0123_4567_89AB_CDEF, {64'h0, 64'h1}, "R2");
        run(2'b00, 8'h40, '0, '0, "R2");
    endtask

    task automatic t_swap_miss_r4_r5();
        run(2'b01, 8'h50, '0, {64'h9999_8888_7777_6666, 64'h8000_0000_0000_0001}, "R5");
        run(2'b10, 8'h50, 64'h8000_0000_0000_0000, '1, "R4");
        run(2'b10, 8'h50, 64'h0000_0000_0000_0001, '1, "R4");
        run(2'b10, 8'h50, 64'h9999_8888_7777_6666, '1, "R4");
        run(2'b00, 8'h50, '0, '0, "R4");
        run(2'b10, 8'h50, 64'h8000_0000_0000_0001, 128'h42, "R5");
        run(2'b00, 8'h50, '0, '0, "R5");
    endtask

    task automatic t_misaligned_r7();
        run(2'b01, 8'h60, '0, 128'h0000_0000_0000_0000_0000_0000_0000_0005, "R7");
        run(2'b10, 8'h61, 64'h5, '1, "R7");
        run(2'b01, 8'h68, '0, '1, "R7");
        run(2'b00, 8'h6F, '0, '0, "R7");
        run(2'b00, 8'h60, '0, '0, "R7");
    endtask

    task automatic t_stall_r9();
        logic [127:0] swap_new, late_wd;
        swap_new = {64'h7777_7777_7777_7777, 64'h2};
        late_wd  = {64'hBBBB_BBBB_BBBB_BBBB, 64'h3};
        run(2'b01, 8'h70, '0, {64'h0, 64'h1}, "R9");
        @(negedge clk);
        req_op = 2'b10; req_addr = 8'h70; req_expect = 64'h1; req_wdata = swap_new;
        req_valid = 1'b1;
        @(negedge clk);
        req_op = 2'b01; req_wdata = late_wd;
        for (int k = 1; k <= 3; k++) begin
            chk(!req_ready, "R9", "busy while write waits", {127'd0, req_ready}, 128'd0);
            if (k == 3)
                chk(rsp_valid && rsp_ok && rsp_data == {64'h0, 64'h1}, "R9", "swap response",
                    rsp_data, {64'h0, 64'h1});
            @(negedge clk);
        end
        chk(req_ready, "R9", "ready after swap", {127'd0, req_ready}, 128'd1);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(rsp_valid && rsp_ok && rsp_data == swap_new, "R9", "late write sees swap result",
            rsp_data, swap_new);
        @(negedge clk);
        model[7] = late_wd;
        run(2'b00, 8'h70, '0, '0, "R9");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_r1();
        t_plain_r8();
        t_swap_hit_r3();
        t_upper_ignored_r2();
        t_swap_miss_r4_r5();
        t_misaligned_r7();
        t_stall_r9();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule